// File: doc/BRIEF.md
# Glitch-Free Clock Root Selector with Half-Step Divider

This block produces one root clock from a set of independent source clocks. A small synchronous register port gives software two words. One is a configuration word that holds a source index and a divider code. The other is a command word that carries an apply request and two status flags.

Configuration writes land in a shadow copy and change nothing at once. Software then sets the apply bit. The block stops the running source on that source's own falling edge and waits until it sees that source has stopped. It then loads the shadow values into the live settings and restarts the chosen source through a two-stage synchronizer. The apply bit clears only when the new source is running. A divider code N gives an output period of (N+1)/2 source periods, so ratios of 1, 1.5, 2, 2.5 and so on are all available. Code 0 passes the source straight through.

Top module: `clkroot_muxdiv`

## Requirements
- R1: After reset, once the first source has started (within 20 bus cycles of reset release), the command word reads 0, the configuration word reads 0, and the output runs at the rate of source 0, undivided.
- R2: A write to the configuration word (base+4; divider code in bits [DIV_SHIFT +: DIV_W], source index in bits [SRC_SHIFT +: SRC_W]) changes neither the output nor the live settings. It sets the pending flag (command bit 4), and the word reads back as written, masked to those two fields.
- R3: Writing the command word (base+0) with bit 0 set while no apply is running starts an apply. Bit 0 reads 1 from the next cycle until the new settings drive the output, and it reads 0 again within 500 bus cycles.
- R4: When an apply completes with no configuration write made during it, the pending flag reads 0.
- R5: For a divider code N from 1 up to its maximum, the output period is (N+1) half-periods of the selected source and the high time is floor((N+2)/2) half-periods.
- R6: Divider code 0 passes the selected source through unchanged: the period is one source period and the high time is half of it.
- R7: Source index s selects source s when s < NSRC. An index of NSRC or above selects source 0.
- R8: At no time are two source gates open together, and the apply sequence never opens the new gate before the old gate is seen closed.
- R9: While an apply is running, a further command write with bit 0 set has no effect. A configuration write made during an apply updates only the shadow copy and leaves the pending flag at 1 after the apply completes.
- R10: Command bit 31 reads 1 while no source gate is open (inside an apply) and 0 while a source drives the output.
- R11: Writes to any address other than base+0 and base+4 change no state, and reads from such addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register-port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe for the word at bus_addr |
| bus_addr | input | ADDR_W | Byte address of the accessed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| src_clk | input | NSRC | Independent source clocks |
| clk_out | output | 1 | Selected and divided root clock |

## Verification
The bench builds the block with three sources, a 2-bit source field and a 4-bit divider field. With these sizes every pair of source index and divider code can be applied and timed: 4 × 16 pairs, which includes the out-of-range index 3 that falls back to source 0. The three sources have periods of 6, 10 and 14 ns, so each ratio, both even and odd half-step codes, and the bypass code are measured against periods that are not multiples of one another. Overlapping command and configuration writes during an apply are also covered.

// File: rtl/clkroot_pkg.sv
`timescale 1ns/1ps
package clkroot_pkg;
   localparam int BUS_W    = 32;
   localparam int CMD_OFS  = 0;
   localparam int CFG_OFS  = 4;
   localparam int CMD_GO   = 0;
   localparam int CMD_PEND = 4;
   localparam int CMD_OFF  = 31;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_DROP  = 2'd1,
      ST_RAISE = 2'd2
   } apply_state_t;
endpackage

// File: rtl/clkroot_gate.sv
`timescale 1ns/1ps
module clkroot_gate (
   input  logic src_clk,
   input  logic bus_clk,
   input  logic rst_n,
   input  logic req,
   output logic gclk,
   output logic en,
   output logic ack
);
   logic sync_a, sync_b, ack_a;

   always_ff @(posedge src_clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_a <= 1'b0;
         sync_b <= 1'b0;
      end else begin
         sync_a <= req;
         sync_b <= sync_a;
      end
   end

   // enable changes only while the source is low
   always_ff @(negedge src_clk or negedge rst_n) begin
      if (!rst_n) en <= 1'b0;
      else        en <= sync_b;
   end

   assign gclk = src_clk & en;

   always_ff @(posedge bus_clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_a <= 1'b0;
         ack   <= 1'b0;
      end else begin
         ack_a <= en;
         ack   <= ack_a;
      end
   end
endmodule

// File: rtl/clkroot_halfdiv.sv
`timescale 1ns/1ps
module clkroot_halfdiv #(
   parameter int DIV_W = 5
) (
   input  logic             clk_in,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] ratio,
   output logic             clk_out
);
   localparam int CW = DIV_W + 1;

   logic [CW-1:0] len, hi_len, pos_r, pos_f, nxt_r, nn_r, nxt_f, nn_f;
   logic          lo_val, hi_val;

   function automatic logic [CW-1:0] step(input logic [CW-1:0] p, input logic [CW-1:0] m);
      return ((p + CW'(1)) >= m) ? '0 : p + CW'(1);
   endfunction

   assign len    = {1'b0, ratio} + CW'(1);
   assign hi_len = (len + CW'(1)) >> 1;

   assign nxt_r = step(pos_f, len);
   assign nn_r  = step(nxt_r, len);
   assign nxt_f = step(pos_r, len);
   assign nn_f  = step(nxt_f, len);

   // rising-edge half: prepares the level shown in the coming low phase
   always_ff @(posedge clk_in or negedge rst_n) begin
      if (!rst_n) begin
         pos_r  <= '0;
         lo_val <= 1'b0;
      end else begin
         pos_r  <= nxt_r;
         lo_val <= (nn_r < hi_len);
      end
   end

   // falling-edge half: prepares the level shown in the coming high phase
   always_ff @(negedge clk_in or negedge rst_n) begin
      if (!rst_n) begin
         pos_f  <= '0;
         hi_val <= 1'b0;
      end else begin
         pos_f  <= nxt_f;
         hi_val <= (nn_f < hi_len);
      end
   end

   assign clk_out = (ratio == '0) ? clk_in : (clk_in ? hi_val : lo_val);
endmodule

// File: rtl/clkroot_ctrl.sv
`timescale 1ns/1ps
module clkroot_ctrl
   import clkroot_pkg::*;
#(
   parameter int          NSRC      = 4,
   parameter int          SRC_W     = 2,
   parameter int          DIV_W     = 5,
   parameter int          SRC_SHIFT = 8,
   parameter int          DIV_SHIFT = 0,
   parameter int          ADDR_W    = 8,
   parameter int unsigned BASE      = 32'h20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   input  logic [NSRC-1:0]   ack,
   output logic [NSRC-1:0]   req,
   output logic [DIV_W-1:0]  live_div,
   output logic              busy,
   output logic              pend
);
   localparam logic [ADDR_W-1:0] A_CMD = ADDR_W'(BASE + CMD_OFS);
   localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(BASE + CFG_OFS);
   localparam logic [BUS_W-1:0]  CFG_MASK =
      (BUS_W'((1 << SRC_W) - 1) << SRC_SHIFT) | (BUS_W'((1 << DIV_W) - 1) << DIV_SHIFT);
   localparam logic [BUS_W-1:0]  GO_MASK = BUS_W'(1) << CMD_GO;
   localparam logic [SRC_W:0]    NSRC_V  = (SRC_W+1)'(NSRC);

   apply_state_t      st;
   logic [BUS_W-1:0]  cfg_q;
   logic [SRC_W-1:0]  sh_src, sh_map, lat_src, live_src;
   logic [DIV_W-1:0]  sh_div, lat_div;
   logic              late_q, hit_cmd, hit_cfg, start, done;

   assign hit_cmd = bus_wr && (bus_addr == A_CMD);
   assign hit_cfg = bus_wr && (bus_addr == A_CFG);
   assign start   = hit_cmd && ((bus_wdata & GO_MASK) != '0) && (st == ST_IDLE);
   assign done    = (st == ST_RAISE) && ((ack & req) != '0);
   assign sh_src  = cfg_q[SRC_SHIFT +: SRC_W];
   assign sh_div  = cfg_q[DIV_SHIFT +: DIV_W];
   assign sh_map  = ({1'b0, sh_src} < NSRC_V) ? sh_src : '0;
   assign busy    = (st != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         cfg_q    <= '0;
         lat_src  <= '0;
         lat_div  <= '0;
         live_src <= '0;
         live_div <= '0;
         pend     <= 1'b0;
         late_q   <= 1'b0;
      end else begin
         if (hit_cfg) cfg_q <= bus_wdata & CFG_MASK;
         case (st)
            ST_IDLE: if (start) begin
               lat_src <= sh_map;
               lat_div <= sh_div;
               st      <= ST_DROP;
            end
            ST_DROP: if (ack == '0) begin
               live_src <= lat_src;
               live_div <= lat_div;
               st       <= ST_RAISE;
            end
            ST_RAISE: if (done) st <= ST_IDLE;
            default: st <= ST_IDLE;
         endcase
         if (start)                 late_q <= 1'b0;
         else if (hit_cfg && busy)  late_q <= 1'b1;
         if (hit_cfg)               pend <= 1'b1;
         else if (done)             pend <= late_q;
      end
   end

   for (genvar i = 0; i < NSRC; i++) begin : g_req
      assign req[i] = (st != ST_DROP) && (live_src == SRC_W'(i));
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == A_CMD) begin
         bus_rdata[CMD_GO]   = busy;
         bus_rdata[CMD_PEND] = pend;
         bus_rdata[CMD_OFF]  = (ack == '0);
      end else if (bus_addr == A_CFG) begin
         bus_rdata = cfg_q;
      end
   end
endmodule

// File: rtl/clkroot_muxdiv.sv
`timescale 1ns/1ps
module clkroot_muxdiv
   import clkroot_pkg::*;
#(
   parameter int          NSRC      = 4,
   parameter int          SRC_W     = 2,
   parameter int          DIV_W     = 5,
   parameter int          SRC_SHIFT = 8,
   parameter int          DIV_SHIFT = 0,
   parameter int          ADDR_W    = 8,
   parameter int unsigned BASE      = 32'h20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic [NSRC-1:0]   src_clk,
   output logic              clk_out
);
   if (NSRC < 2 || NSRC > (1 << SRC_W)) begin : g_bad_nsrc
      $error("clkroot_muxdiv: NSRC must be in 2..2**SRC_W");
   end
   if (SRC_SHIFT + SRC_W > BUS_W || DIV_SHIFT + DIV_W > BUS_W) begin : g_bad_fit
      $error("clkroot_muxdiv: fields exceed the data word");
   end
   if (!(SRC_SHIFT >= DIV_SHIFT + DIV_W || DIV_SHIFT >= SRC_SHIFT + SRC_W)) begin : g_bad_overlap
      $error("clkroot_muxdiv: fields overlap");
   end
   if (BASE % 4 != 0) begin : g_bad_base
      $error("clkroot_muxdiv: BASE must be word aligned");
   end

   logic [NSRC-1:0]  gate_req, gate_en, gate_ack, gclk;
   logic [DIV_W-1:0] live_div;
   logic             upd_busy, cfg_pend, root_clk;

   clkroot_ctrl #(
      .NSRC(NSRC), .SRC_W(SRC_W), .DIV_W(DIV_W), .SRC_SHIFT(SRC_SHIFT),
      .DIV_SHIFT(DIV_SHIFT), .ADDR_W(ADDR_W), .BASE(BASE)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ack(gate_ack),
      .req(gate_req), .live_div(live_div), .busy(upd_busy), .pend(cfg_pend)
   );

   for (genvar i = 0; i < NSRC; i++) begin : g_src
      clkroot_gate u_gate (
         .src_clk(src_clk[i]), .bus_clk(clk), .rst_n(rst_n), .req(gate_req[i]),
         .gclk(gclk[i]), .en(gate_en[i]), .ack(gate_ack[i])
      );
   end

   assign root_clk = |gclk;

   clkroot_halfdiv #(.DIV_W(DIV_W)) u_div (
      .clk_in(root_clk), .rst_n(rst_n), .ratio(live_div), .clk_out(clk_out)
   );
endmodule

// File: rtl/clkroot_muxdiv_chk.sv
`timescale 1ns/1ps
module clkroot_muxdiv_chk #(
   parameter int          NSRC       = 4,
   parameter int          ADDR_W     = 8,
   parameter int unsigned BASE       = 32'h20,
   parameter int          BUSY_LIMIT = 500
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input logic [NSRC-1:0]   gate_en,
   input logic [NSRC-1:0]   ack,
   input logic              busy,
   input logic              pend
);
   localparam logic [ADDR_W-1:0] A_CMD = ADDR_W'(BASE);
   localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(BASE + 4);

   logic [15:0] busy_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    busy_cnt <= '0;
      else if (busy) busy_cnt <= busy_cnt + 16'd1;
      else           busy_cnt <= '0;
   end

   p_one_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gate_en) && $onehot0(ack));

   p_start_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(bus_wr && bus_addr == A_CMD && ((bus_wdata & 32'h1) != 0)));

   p_live_at_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (ack != '0));

   p_bounded_r3: assert property (@(posedge clk) disable iff (!rst_n)
      busy_cnt < 16'(BUSY_LIMIT));

   p_pend_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == A_CFG) |=> pend);

   p_pend_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && busy) |=> (pend || !busy));
endmodule

bind clkroot_muxdiv clkroot_muxdiv_chk #(
   .NSRC(NSRC), .ADDR_W(ADDR_W), .BASE(BASE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .gate_en(gate_en), .ack(gate_ack),
   .busy(upd_busy), .pend(cfg_pend)
);

// File: tb/tb_clkroot_muxdiv.sv
`timescale 1ns/1ps
module tb_clkroot_muxdiv;
   localparam int NSRC = 3, SRC_W = 2, DIV_W = 4, SRC_SHIFT = 8, DIV_SHIFT = 0, ADDR_W = 8;
   localparam int unsigned BASE = 32'h20;
   localparam logic [7:0] A_CMD = 8'h20, A_CFG = 8'h24;

   logic clk = 0, rst_n = 0, bus_wr = 0, clk_out;
   logic [7:0]  bus_addr = 0;
   logic [31:0] bus_wdata = 0, bus_rdata;
   logic [NSRC-1:0] src_clk = '0;
   int checks = 0, fails = 0;
   real sper [NSRC] = '{6.0, 10.0, 14.0};

   always #5 clk = ~clk;
   always #3 src_clk[0] = ~src_clk[0];
   always #5 src_clk[1] = ~src_clk[1];
   always #7 src_clk[2] = ~src_clk[2];

   clkroot_muxdiv #(.NSRC(NSRC), .SRC_W(SRC_W), .DIV_W(DIV_W), .SRC_SHIFT(SRC_SHIFT),
      .DIV_SHIFT(DIV_SHIFT), .ADDR_W(ADDR_W), .BASE(BASE)) dut (.*);

   task automatic chk_int(input string tag, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic chk_real(input string tag, input real act, input real exp);
      checks++;
      if (act - exp > 0.01 || exp - act > 0.01) begin
         fails++;
         $display("FAIL %s actual=%0.3f expected=%0.3f", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] cfgw(input int s, input int n);
      return (32'(s) << SRC_SHIFT) | (32'(n) << DIV_SHIFT);
   endfunction

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
      @(negedge clk); bus_wr = 0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk); bus_addr = a; #1 d = bus_rdata;
   endtask

   task automatic measure(output real per, output real hi);
      real t0, t1, t2;
      repeat (3) @(posedge clk_out);
      t0 = $realtime; @(negedge clk_out);
      t1 = $realtime; @(posedge clk_out);
      t2 = $realtime;
      per = t2 - t0; hi = t1 - t0;
   endtask

   task automatic wait_done(output int cycles, output bit saw_off);
      logic [31:0] d;
      cycles = 0; saw_off = 0;
      rd(A_CMD, d);
      while (d[0] && cycles <= 500) begin
         if (d[31]) saw_off = 1;
         rd(A_CMD, d);
         cycles++;
      end
   endtask

   task automatic expect_clk(input string tag, input int s, input int n);
      real per, hi, p;
      p = sper[(s < NSRC) ? s : 0];
      measure(per, hi);
      if (n == 0) begin
         chk_real({tag, " R6 bypass period"}, per, p);
         chk_real({tag, " R6 bypass high"}, hi, p / 2.0);
      end else begin
         chk_real({tag, " R5 period"}, per, (n + 1) * p / 2.0);
         chk_real({tag, " R5 high"}, hi, ((n + 2) / 2) * p / 2.0);
      end
   endtask

   initial begin
      #1500000;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [31:0] d;
      int cyc;
      bit off;
      repeat (5) @(negedge clk);
      rst_n = 1;
      repeat (20) @(negedge clk);
      // R1 reset state
      rd(A_CMD, d); chk_int("R1 cmd after reset", d, 0);
      rd(A_CFG, d); chk_int("R1 cfg after reset", d, 0);
      expect_clk("R1", 0, 0);
      // R2 shadow write
      wr(A_CFG, cfgw(1, 3) | 32'hF000_0000);
      rd(A_CMD, d); chk_int("R2 pending after cfg write", d, 32'h10);
      rd(A_CFG, d); chk_int("R2 cfg readback", d, cfgw(1, 3));
      expect_clk("R2 unchanged", 0, 0);
      // R11 decode
      wr(8'h04, cfgw(2, 7));
      wr(A_CFG + 8'd8, 32'hFFFF_FFFF);
      wr(A_CMD + 8'd12, 32'h1);
      rd(A_CFG, d); chk_int("R11 cfg untouched", d, cfgw(1, 3));
      rd(A_CFG + 8'd8, d); chk_int("R11 unmapped read", d, 0);
      rd(8'h00, d); chk_int("R11 read below base", d, 0);
      rd(A_CMD, d); chk_int("R11 no apply started", d, 32'h10);
      // sweep of every source index and divider code (R3 R4 R5 R6 R7 R10)
      for (int s = 0; s < (1 << SRC_W); s++) begin
         for (int n = 0; n < (1 << DIV_W); n++) begin
            wr(A_CFG, cfgw(s, n));
            wr(A_CMD, 32'h1);
            rd(A_CMD, d); chk_int("R3 busy after go", d[0], 1);
            wait_done(cyc, off);
            chk_int("R3 apply bounded", (cyc <= 500), 1);
            chk_int("R10 root off seen during apply", off, 1);
            rd(A_CMD, d); chk_int("R4 R10 cmd after apply", d, 0);
            expect_clk($sformatf("R7 s=%0d n=%0d", s, n), s, n);
         end
      end
      // R9 overlapping writes during an apply
      wr(A_CFG, cfgw(2, 5));
      wr(A_CMD, 32'h1);
      wr(A_CMD, 32'h1);
      wr(A_CFG, cfgw(0, 2));
      wait_done(cyc, off);
      rd(A_CMD, d); chk_int("R9 pending kept after apply", d, 32'h10);
      rd(A_CFG, d); chk_int("R9 shadow holds late write", d, cfgw(0, 2));
      expect_clk("R9 first settings live", 2, 5);
      wr(A_CMD, 32'h1);
      wait_done(cyc, off);
      rd(A_CMD, d); chk_int("R4 pending cleared", d, 0);
      expect_clk("R9 second apply", 0, 2);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule